// File: doc/BRIEF.md
# Memory Boundary-Scan Test Port

This block is the serial test port of a synchronous memory. A host that drives `tck`, `tms` and `tdi` walks a sixteen-state controller. Through it the host loads a three-bit instruction and then shifts one data register between `tdi` and `tdo`. There are three data registers: a one-bit pass-through stage, a 32-bit identity word and a parallel-capture chain. The capture chain samples the memory's I/O ring, taken from `ring_in`.

Two instructions turn off the memory's output drivers through `force_hiz`. One of them is a non-standard variant that samples the ring. The sampling instruction without that override captures only and never updates any output latch. Unused codes behave like the pass-through instruction. The pad drivers and the memory array sit outside the block. The block reports the output-enable for the `tdo` pad as `tdo_oe`, and it reports which data register is in the path as `dr_sel`.

Top module: `scan_tap`

## Requirements
- R1: The controller follows the standard sixteen-state diagram on rising `tck` edges. Five consecutive rising edges with `tms` high reach Test-Logic-Reset from any state.
- R2: While `trst_n` is low, the following hold at once, without waiting for a clock: the controller is in Test-Logic-Reset, the instruction is 001, `tdo_oe` is 0 and `force_hiz` is 0.
- R3: Instruction codes: 000 external test, 001 identity, 010 sample with high-Z, 100 sample, 111 pass-through. `dr_sel` is 0 for the pass-through stage, 1 for the identity word and 2 for the capture chain. The three sampling/test codes select 2.
- R4: The reserved codes 011, 101 and 110 select the pass-through stage (`dr_sel`=0) and keep `force_hiz` at 0.
- R5: Under the identity instruction, Capture-DR loads the parameter `ID_VALUE`, which is then shifted out least significant bit first.
- R6: The pass-through stage captures 0 and delays `tdi` by exactly one shift.
- R7: Capture-IR loads 001. Shifting the instruction register therefore emits 1, 0, 0.
- R8: A newly shifted instruction takes effect only on the falling `tck` edge in Update-IR. Until then `force_hiz` and `dr_sel` keep the previous instruction's values, including in Exit1-IR. Entering Test-Logic-Reset restores instruction 001.
- R9: `force_hiz` is 1 exactly under the codes 000 and 010.
- R10: Under codes 000, 010 and 100, Capture-DR loads `ring_in` into the chain, and bit 0 leaves first.
- R11: Under code 100, Update-DR transfers nothing. A later capture returns the current `ring_in` and not the shifted-in data, and `force_hiz` stays 0.
- R12: `tdo` and `tdo_oe` change only on falling `tck` edges. `tdo_oe` is 1 only while the controller is in Shift-DR or Shift-IR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| trst_n | input | 1 | Asynchronous active-low test reset |
| ring_in | input | RING_W | Parallel sample of the memory I/O ring |
| tdo | output | 1 | Serial data out, valid when `tdo_oe` is 1 |
| tdo_oe | output | 1 | Enable for the `tdo` pad driver |
| force_hiz | output | 1 | Forces the memory output drivers to high impedance |
| dr_sel | output | 2 | Active data register: 0 pass-through, 1 identity, 2 capture chain |

## Verification
A controller stuck in the wrong state shows up within one falling edge. `tdo_oe` rises or fails to rise, or the first shifted bit differs from the expected capture value of 0, the identity LSB or ring bit 0. A wrong instruction latch shows up at the very next falling edge of Update-IR as a wrong `force_hiz` or `dr_sel`. An early update is caught as a change already visible in Exit1-IR. A broken shift path or a leaked preload appears only after a full scan, when the bit sequence that comes out is compared, so those faults surface within one register length.

// File: rtl/scan_tap.sv
module scan_tap #(
  parameter int          RING_W   = 8,
  parameter logic [31:0] ID_VALUE = 32'h1A5C_3E01
) (
  input  logic              tck,
  input  logic              tms,
  input  logic              tdi,
  input  logic              trst_n,
  input  logic [RING_W-1:0] ring_in,
  output logic              tdo,
  output logic              tdo_oe,
  output logic              force_hiz,
  output logic [1:0]        dr_sel
);
  localparam int IR_W = 3;
  localparam logic [IR_W-1:0] OP_EXTEST = 3'b000;
  localparam logic [IR_W-1:0] OP_IDENT  = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPZ  = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE = 3'b100;
  localparam logic [1:0] SEL_PASS = 2'd0, SEL_ID = 2'd1, SEL_RING = 2'd2;

  typedef enum logic [3:0] {
    S_TLR, S_RTI, S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR,
    S_UPD_DR, S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
  } tap_st_t;

  tap_st_t state, state_nx;
  logic [IR_W-1:0]   ir_q, ir_sh;
  logic              pass_q;
  logic [31:0]       id_sh;
  logic [RING_W-1:0] ring_sh;

  always_comb begin
    case (state)
      S_TLR:    state_nx = tms ? S_TLR    : S_RTI;
      S_RTI:    state_nx = tms ? S_SEL_DR : S_RTI;
      S_SEL_DR: state_nx = tms ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: state_nx = tms ? S_EX1_DR : S_SH_DR;
      S_SH_DR:  state_nx = tms ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: state_nx = tms ? S_UPD_DR : S_PAU_DR;
      S_PAU_DR: state_nx = tms ? S_EX2_DR : S_PAU_DR;
      S_EX2_DR: state_nx = tms ? S_UPD_DR : S_SH_DR;
      S_UPD_DR: state_nx = tms ? S_SEL_DR : S_RTI;
      S_SEL_IR: state_nx = tms ? S_TLR    : S_CAP_IR;
      S_CAP_IR: state_nx = tms ? S_EX1_IR : S_SH_IR;
      S_SH_IR:  state_nx = tms ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: state_nx = tms ? S_UPD_IR : S_PAU_IR;
      S_PAU_IR: state_nx = tms ? S_EX2_IR : S_PAU_IR;
      S_EX2_IR: state_nx = tms ? S_UPD_IR : S_SH_IR;
      default:  state_nx = tms ? S_SEL_DR : S_RTI;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) state <= S_TLR;
    else         state <= state_nx;

  always_comb begin
    case (ir_q)
      OP_IDENT:                       dr_sel = SEL_ID;
      OP_EXTEST, OP_SAMPZ, OP_SAMPLE: dr_sel = SEL_RING;
      default:                        dr_sel = SEL_PASS;
    endcase
  end

  assign force_hiz = (ir_q == OP_EXTEST) || (ir_q == OP_SAMPZ);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      pass_q  <= 1'b0;
      id_sh   <= '0;
      ring_sh <= '0;
      ir_sh   <= '0;
    end else begin
      if (state == S_CAP_DR) begin
        case (dr_sel)
          SEL_ID:   id_sh   <= ID_VALUE;
          SEL_RING: ring_sh <= ring_in;
          default:  pass_q  <= 1'b0;
        endcase
      end else if (state == S_SH_DR) begin
        case (dr_sel)
          SEL_ID:   id_sh   <= {tdi, id_sh[31:1]};
          SEL_RING: ring_sh <= {tdi, ring_sh[RING_W-1:1]};
          default:  pass_q  <= tdi;
        endcase
      end
      if (state == S_CAP_IR)     ir_sh <= OP_IDENT;
      else if (state == S_SH_IR) ir_sh <= {tdi, ir_sh[IR_W-1:1]};
    end
  end

  always_ff @(negedge tck or negedge trst_n)
    if (!trst_n)               ir_q <= OP_IDENT;
    else if (state == S_TLR)   ir_q <= OP_IDENT;
    else if (state == S_UPD_IR) ir_q <= ir_sh;

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo_oe <= 1'b0;
      tdo    <= 1'b0;
    end else begin
      tdo_oe <= (state == S_SH_DR) || (state == S_SH_IR);
      if (state == S_SH_IR) tdo <= ir_sh[0];
      else if (state == S_SH_DR)
        case (dr_sel)
          SEL_ID:   tdo <= id_sh[0];
          SEL_RING: tdo <= ring_sh[0];
          default:  tdo <= pass_q;
        endcase
      else tdo <= 1'b0;
    end
  end
endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk (
  input logic       tck,
  input logic       trst_n,
  input logic       tms,
  input logic [3:0] st,
  input logic [2:0] ir,
  input logic       tdo_oe,
  input logic       force_hiz,
  input logic [1:0] dr_sel
);
  localparam logic [3:0] C_TLR = 4'd0, C_SH_DR = 4'd4, C_SH_IR = 4'd11, C_UPD_IR = 4'd15;
  logic [2:0] highs;

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n)           highs <= '0;
    else if (!tms)         highs <= '0;
    else if (highs != 3'd5) highs <= highs + 3'd1;

  p_five_high_r1: assert property (@(posedge tck) disable iff (!trst_n)
    highs == 3'd5 |-> st == C_TLR);
  p_trst_hold_r2: assert property (@(posedge tck)
    !trst_n |-> (st == C_TLR && ir == 3'b001 && !tdo_oe && !force_hiz));
  p_reserved_pass_r4: assert property (@(posedge tck) disable iff (!trst_n)
    (ir == 3'd3 || ir == 3'd5 || ir == 3'd6) |-> (dr_sel == 2'd0 && !force_hiz));
  p_ir_hold_r8: assert property (@(posedge tck) disable iff (!trst_n)
    !(st == C_UPD_IR || st == C_TLR) |-> $stable(ir));
  p_hiz_codes_r9: assert property (@(posedge tck) disable iff (!trst_n)
    force_hiz |-> (ir == 3'd0 || ir == 3'd2));
  p_oe_shift_r12: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe == (st == C_SH_DR || st == C_SH_IR));
endmodule

bind scan_tap scan_tap_chk u_chk (
  .tck(tck), .trst_n(trst_n), .tms(tms), .st(state), .ir(ir_q),
  .tdo_oe(tdo_oe), .force_hiz(force_hiz), .dr_sel(dr_sel)
);

// File: tb/test_scan_tap.sv
module test_scan_tap;
  localparam int          RING_W = 8;
  localparam logic [31:0] IDV    = 32'h1A5C_3E01;

  logic tck = 1'b0, tms = 1'b1, tdi = 1'b0, trst_n = 1'b1;
  logic [RING_W-1:0] ring_in = 8'h00;
  logic tdo, tdo_oe, force_hiz;
  logic [1:0] dr_sel;
  int checks = 0, errors = 0;
  bit done = 0;

  scan_tap #(.RING_W(RING_W), .ID_VALUE(IDV)) i_scan_tap (
    .tck(tck), .tms(tms), .tdi(tdi), .trst_n(trst_n), .ring_in(ring_in),
    .tdo(tdo), .tdo_oe(tdo_oe), .force_hiz(force_hiz), .dr_sel(dr_sel));

  always #5 tck = ~tck;

  // code, expected dr_sel, expected force_hiz
  localparam logic [5:0] VEC [0:7] = '{
    {3'd0, 2'd2, 1'b1}, {3'd1, 2'd1, 1'b0}, {3'd2, 2'd2, 1'b1}, {3'd3, 2'd0, 1'b0},
    {3'd4, 2'd2, 1'b0}, {3'd5, 2'd0, 1'b0}, {3'd6, 2'd0, 1'b0}, {3'd7, 2'd0, 1'b0}};

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic to_idle();
    repeat (5) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  task automatic load_ir(input logic [2:0] code, output logic [2:0] cap,
                         output logic hiz_mid, output logic [1:0] sel_mid);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 3; i++) begin
      cap[i] = tdo;
      step(i == 2, code[i]);
    end
    hiz_mid = force_hiz; sel_mid = dr_sel;
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      step(i == n - 1, din[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge tck);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [2:0] cap; logic hmid, prev_hiz; logic [1:0] smid, prev_sel;
    logic [63:0] got;
    #2 trst_n = 1'b0;
    #1;
    chk("R2 reset oe", tdo_oe, 0);
    chk("R2 reset hiz", force_hiz, 0);
    chk("R2 reset sel", dr_sel, 1);
    @(negedge tck); #1 trst_n = 1'b1;
    to_idle();
    chk("R12 idle oe", tdo_oe, 0);
    prev_hiz = 1'b0; prev_sel = 2'd1;
    ring_in = 8'hC6;

    for (int v = 0; v < 8; v++) begin
      load_ir(VEC[v][5:3], cap, hmid, smid);
      chk("R7 ir capture", cap, 3'b001);
      chk("R8 hiz before update", hmid, prev_hiz);
      chk("R8 sel before update", smid, prev_sel);
      chk("R3 R4 dr_sel", dr_sel, VEC[v][2:1]);
      chk("R9 force_hiz", force_hiz, VEC[v][0]);
      case (VEC[v][2:1])
        2'd1: begin scan_dr(32, 64'h0, got); chk("R5 ident", got[31:0], IDV); end
        2'd2: begin scan_dr(RING_W, 64'h0, got); chk("R10 ring", got[RING_W-1:0], ring_in); end
        default: begin scan_dr(4, 64'hB, got); chk("R6 R4 pass", got[3:0], 4'b0110); end
      endcase
      prev_hiz = VEC[v][0]; prev_sel = VEC[v][2:1];
    end

    load_ir(3'd4, cap, hmid, smid);
    ring_in = 8'hA5;
    scan_dr(RING_W, 64'h3C, got);
    chk("R11 first capture", got[RING_W-1:0], 8'hA5);
    scan_dr(RING_W, 64'h00, got);
    chk("R11 no preload", got[RING_W-1:0], 8'hA5);
    chk("R11 hiz low", force_hiz, 0);
    ring_in = 8'h5A;
    scan_dr(RING_W, 64'h00, got);
    chk("R11 live ring", got[RING_W-1:0], 8'h5A);

    load_ir(3'd0, cap, hmid, smid);
    chk("R9 extest hiz", force_hiz, 1);
    step(1, 0); step(0, 0); step(0, 0);
    chk("R12 shift oe", tdo_oe, 1);
    repeat (5) step(1, 0);
    chk("R1 tlr from shift-dr sel", dr_sel, 1);
    chk("R1 tlr from shift-dr hiz", force_hiz, 0);
    step(0, 0);
    load_ir(3'd2, cap, hmid, smid);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0); step(1, 0); step(0, 0);
    repeat (5) step(1, 0);
    chk("R1 tlr from pause-ir", force_hiz, 0);
    step(0, 0);

    load_ir(3'd7, cap, hmid, smid);
    step(1, 0); step(0, 0); step(0, 0);
    chk("R6 captured zero", tdo, 0);
    tms = 0; tdi = 1;
    @(posedge tck); #1;
    chk("R12 no change at rise", tdo, 0);
    @(negedge tck); #1;
    chk("R12 change at fall", tdo, 1);
    step(1, 0);
    chk("R12 exit1 oe", tdo_oe, 0);
    step(1, 0); step(0, 0);

    load_ir(3'd0, cap, hmid, smid);
    step(1, 0); step(0, 0); step(0, 0);
    #1 trst_n = 1'b0;
    #1;
    chk("R2 async oe", tdo_oe, 0);
    chk("R2 async hiz", force_hiz, 0);
    chk("R2 async sel", dr_sel, 1);
    @(negedge tck); #1 trst_n = 1'b1;
    to_idle();
    finish_run();
  end
endmodule